// File: doc/BRIEF.md
# SD Host Simple-DMA Block Sequencer

This block runs simple-DMA data transfers for an SD host controller. Software programs four registers through a 32-bit write port with per-byte enables: the system address, the block size with its boundary code, the block count, and the transfer mode. Writing the most significant byte of the command half starts a command. When DMA is enabled and selected, the block then issues one memory request per block to a data path over a valid/ready handshake.

A start is checked before any request is issued. A multi-block transfer is refused unless block counting is enabled and the count is nonzero, so a transfer with no end can never begin. A transfer with a count of one, or with the multi-block bit clear, runs as a single block. A multi-block transfer counts down one block per accepted request and signals completion when the count reaches zero. When a block crosses the programmed address boundary and blocks remain, the sequencer stops and raises a boundary interrupt. Software restarts it by rewriting the system address.

The request interface follows the usual back-pressure rule. Once `req_valid` is high, it stays high with the same address and length until `req_ready` is seen high at a clock edge. A block is complete at that edge. The data path may hold `req_ready` low for any number of cycles.

Top module: `sdma_seq`

## Requirements
- R1: After reset, register words 0, 1 and 2 read zero, and `req_valid`, `busy`, `cmd_start`, `irq_done` and `irq_bound` are low.
- R2: Word 2 bits 15:0 hold the transfer mode. Only bits 0 (DMA enable), 1 (count enable), 2, 4 (read direction, shown on `req_rd`) and 5 (multi-block) can be written, which is mask 0x0037. All other bits read zero.
- R3: While `cap_dma` is low, every write to the transfer mode stores bit 0 as zero.
- R4: A write changes only the bytes whose `wr_be` bit is set. Word 0 is the system address. Word 1 holds the block size in bits 11:0, the boundary code in bits 14:12 and the block count in bits 31:16. Word 1 bit 15 always reads zero.
- R5: `cmd_start` pulses high for one cycle, in the cycle after a write to word 2 with `wr_be[3]` set. A write to word 2 without `wr_be[3]` gives no pulse.
- R6: A transfer starts only if transfer-mode bit 0 is set and `dma_sel` equals 0 (simple DMA) on the cycle `cmd_start` is high. Otherwise no request is made.
- R7: If the multi-block bit is set while the count-enable bit is clear or the block count is zero, no request is made and `busy` stays low.
- R8: If the multi-block bit is clear or the count is 1, exactly one request is made at the system address. `irq_done` then pulses, and the block count is left unchanged.
- R9: In a multi-block transfer, each accepted request adds the block size to the system address and subtracts 1 from the count. The transfer ends with an `irq_done` pulse when the count reaches zero.
- R10: The boundary size is 1 << (code + 12) bytes. The bytes left are that size minus (address modulo the size), taken at the block's address. If the bytes left are no more than the block size and blocks remain, the sequencer pauses, `irq_bound` pulses, and `busy` stays high.
- R11: A write to word 0 while paused resumes requests at the written address.
- R12: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` holds its value, unless word 0 is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word index |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Per-byte write enables |
| rd_addr | input | 2 | Read word index |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| cap_dma | input | 1 | High when DMA is supported |
| dma_sel | input | 2 | DMA type select; 0 picks simple DMA |
| cmd_start | output | 1 | Command generation pulse |
| req_valid | output | 1 | Block request valid |
| req_ready | input | 1 | Data path accepts the request |
| req_addr | output | 32 | Memory address of the block |
| req_len | output | 12 | Block size in bytes |
| req_rd | output | 1 | Transfer direction (mode bit 4) |
| busy | output | 1 | Transfer active or paused |
| irq_done | output | 1 | Transfer complete pulse |
| irq_bound | output | 1 | Boundary pause pulse |

## Verification
A register write takes effect at its clock edge, so read-back and `cmd_start` are checked in the next cycle. The first `req_valid` follows one cycle after `cmd_start`. `irq_done`, `irq_bound`, the advanced address and the decremented count all appear in the cycle right after the accepting edge, and a resume write brings `req_valid` back in the cycle after that write. The bench drives inputs and samples outputs on the falling edge, at those cycles only. It holds `req_ready` low at random to test back-pressure, and it gets the expected pause points from its own boundary model.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [15:0] TM_MASK = 16'h0037;
  localparam int TM_DMA   = 0;
  localparam int TM_BCE   = 1;
  localparam int TM_RD    = 4;
  localparam int TM_MULTI = 5;
  localparam logic [1:0] W_ADDR = 2'd0;
  localparam logic [1:0] W_BLK  = 2'd1;
  localparam logic [1:0] W_CMD  = 2'd2;
  localparam logic [1:0] SEL_SDMA = 2'd0;
  localparam int BSZ_W  = 12;
  localparam int CODE_W = 3;
  localparam int BND_BASE = 12;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_PAUSE} seq_st_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/8-1:0]   wr_be,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              cap_dma,
  input  logic              adv,
  input  logic              dec,
  output logic [DW-1:0]     sysaddr,
  output logic [DW/2-2:0]   bsz,
  output logic [DW/2-1:0]   blkcnt,
  output logic [DW/2-1:0]   tmode,
  output logic              cmd_trig,
  output logic              addr_wr
);
  localparam int HW = DW / 2;
  localparam int NB = DW / 8;

  logic [HW-1:0] cmd_q;
  logic [DW-1:0] m_addr, m_blk, m_cmd;
  logic [HW-1:0] tm_keep;
  logic sel_a, sel_b, sel_c;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  assign sel_a   = wr_en && (wr_addr == W_ADDR);
  assign sel_b   = wr_en && (wr_addr == W_BLK);
  assign sel_c   = wr_en && (wr_addr == W_CMD);
  assign addr_wr = sel_a && (|wr_be);
  assign m_addr  = merge(sysaddr, wr_data, wr_be);
  assign m_blk   = merge({blkcnt, 1'b0, bsz}, wr_data, wr_be);
  assign m_cmd   = merge({cmd_q, tmode}, wr_data, wr_be);
  assign tm_keep = TM_MASK & (cap_dma ? {HW{1'b1}} : ~HW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sysaddr  <= '0;
      bsz      <= '0;
      blkcnt   <= '0;
      tmode    <= '0;
      cmd_q    <= '0;
      cmd_trig <= 1'b0;
    end else begin
      if (sel_a) sysaddr <= m_addr;
      else if (adv) sysaddr <= sysaddr + DW'(bsz[BSZ_W-1:0]);
      if (sel_b) begin
        bsz    <= m_blk[HW-2:0];
        blkcnt <= m_blk[DW-1:HW];
      end else if (dec) begin
        blkcnt <= blkcnt - 1'b1;
      end
      if (sel_c) begin
        tmode <= m_cmd[HW-1:0] & tm_keep;
        cmd_q <= m_cmd[DW-1:HW];
      end
      cmd_trig <= sel_c && wr_be[NB-1];
    end
  end

  always_comb begin
    case (rd_addr)
      W_ADDR:  rd_data = sysaddr;
      W_BLK:   rd_data = {blkcnt, 1'b0, bsz};
      W_CMD:   rd_data = {cmd_q, tmode};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sdma_bound.sv
module sdma_bound
  import sdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     addr,
  input  logic [CODE_W-1:0] code,
  input  logic [BSZ_W-1:0]  blksz,
  output logic [AW-1:0]     left,
  output logic              hit
);
  localparam int SHW = $clog2(AW) + 1;
  logic [SHW-1:0] sh;
  logic [AW-1:0]  bnd;

  assign sh   = SHW'(code) + SHW'(BND_BASE);
  assign bnd  = AW'(1) << sh;
  assign left = bnd - (addr & (bnd - AW'(1)));
  assign hit  = left <= AW'(blksz);
endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
  import sdma_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_trig,
  input  logic [TW-1:0] tmode,
  input  logic [CW-1:0] blkcnt,
  input  logic [1:0]    dma_sel,
  input  logic          hit,
  input  logic          resume,
  input  logic          req_ready,
  output logic          req_valid,
  output logic          adv,
  output logic          dec,
  output logic          busy,
  output logic          irq_done,
  output logic          irq_bound
);
  seq_st_e st_q;
  logic    single_q;
  logic    hs, multi, refuse, last;

  assign multi     = tmode[TM_MULTI];
  assign refuse    = multi && (!tmode[TM_BCE] || (blkcnt == '0));
  assign req_valid = (st_q == ST_XFER);
  assign busy      = (st_q != ST_IDLE);
  assign hs        = req_valid && req_ready;
  assign adv       = hs;
  assign dec       = hs && !single_q;
  assign last      = single_q || (blkcnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      single_q  <= 1'b0;
      irq_done  <= 1'b0;
      irq_bound <= 1'b0;
    end else begin
      irq_done  <= 1'b0;
      irq_bound <= 1'b0;
      case (st_q)
        ST_IDLE:
          if (cmd_trig && tmode[TM_DMA] && (dma_sel == SEL_SDMA) && !refuse) begin
            st_q     <= ST_XFER;
            single_q <= !multi || (blkcnt == CW'(1));
          end
        ST_XFER:
          if (hs) begin
            if (last) begin
              st_q     <= ST_IDLE;
              irq_done <= 1'b1;
            end else if (hit) begin
              st_q      <= ST_PAUSE;
              irq_bound <= 1'b1;
            end
          end
        ST_PAUSE:
          if (resume) st_q <= ST_XFER;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] wr_be,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            cap_dma,
  input  logic [1:0]      dma_sel,
  output logic            cmd_start,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [DW-1:0]   req_addr,
  output logic [BSZ_W-1:0] req_len,
  output logic            req_rd,
  output logic            busy,
  output logic            irq_done,
  output logic            irq_bound
);
  localparam int HW = DW / 2;

  logic [DW-1:0] sysaddr;
  logic [HW-2:0] bsz;
  logic [HW-1:0] blkcnt, tmode;
  logic          adv, dec, addr_wr, hit;
  logic [DW-1:0] left;

  sdma_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_dma(cap_dma), .adv(adv), .dec(dec), .sysaddr(sysaddr), .bsz(bsz),
    .blkcnt(blkcnt), .tmode(tmode), .cmd_trig(cmd_start), .addr_wr(addr_wr)
  );

  sdma_bound #(.AW(DW)) u_bound (
    .addr(sysaddr), .code(bsz[BSZ_W+CODE_W-1:BSZ_W]), .blksz(bsz[BSZ_W-1:0]),
    .left(left), .hit(hit)
  );

  sdma_fsm #(.CW(HW), .TW(HW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_trig(cmd_start), .tmode(tmode),
    .blkcnt(blkcnt), .dma_sel(dma_sel), .hit(hit), .resume(addr_wr),
    .req_ready(req_ready), .req_valid(req_valid), .adv(adv), .dec(dec),
    .busy(busy), .irq_done(irq_done), .irq_bound(irq_bound)
  );

  assign req_addr = sysaddr;
  assign req_len  = bsz[BSZ_W-1:0];
  assign req_rd   = tmode[TM_RD];
endmodule

// File: rtl/sdma_seq_chk.sv
module sdma_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [3:0]  wr_be,
  input logic [1:0]  dma_sel,
  input logic        cmd_start,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        irq_done,
  input logic        irq_bound,
  input logic [15:0] tmode,
  input logic [15:0] blkcnt
);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !(wr_en && wr_addr == 2'd0)
    |=> req_valid && $stable(req_addr));

  a_r5_cmd_src: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(wr_en && wr_addr == 2'd2 && wr_be[3]));

  a_r6_dma_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && $past(cmd_start) |-> $past(tmode[0] && dma_sel == 2'd0));

  a_r7_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && $past(cmd_start)
    |-> $past(!tmode[5] || (tmode[1] && blkcnt != 16'd0)));

  a_r9_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(req_valid && req_ready));

  a_r10_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done, irq_bound}));

  a_r11_resume_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cmd_start) || $past(wr_en && wr_addr == 2'd0));
endmodule

bind sdma_seq sdma_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
  .dma_sel(dma_sel), .cmd_start(cmd_start), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .irq_done(irq_done),
  .irq_bound(irq_bound), .tmode(tmode), .blkcnt(blkcnt)
);

// File: tb/sdma_seq_tb.sv
`timescale 1ns/1ps
module sdma_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cap_dma = 1'b1;
  logic [1:0]  dma_sel = '0;
  logic        cmd_start, req_valid, req_rd, busy, irq_done, irq_bound;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [11:0] req_len;
  int nchk = 0;
  int nfail = 0;

  sdma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_dma(cap_dma), .dma_sel(dma_sel), .cmd_start(cmd_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_rd(req_rd), .busy(busy), .irq_done(irq_done),
    .irq_bound(irq_bound)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic longint bleft(input logic [31:0] a, input int code);
    longint bnd = longint'(1) << (code + 12);
    return bnd - (longint'(a) % bnd);
  endfunction

  task automatic no_start(input string tag, input logic [15:0] tm, input logic [15:0] cnt);
    logic seen;
    wr(1, {cnt, 16'h0200}, 4'hF);
    wr(2, {16'h1100, tm}, 4'hF);
    chk(cmd_start == 1'b1, {tag, " cmd_start"}, cmd_start, 1);
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req_valid || busy) seen = 1'b1;
    end
    chk(!seen, {tag, " no request"}, seen, 0);
  endtask

  task automatic run_xfer(input string tag, input logic [31:0] addr, input int bs,
                          input int code, input int cnt, input logic [15:0] tm);
    logic [31:0] a, d;
    int rem, guard;
    bit single, hs, done;
    longint lf;
    a = addr; rem = cnt; single = !tm[5] || (cnt == 1); done = 0; guard = 0;
    wr(0, addr, 4'hF);
    wr(1, {cnt[15:0], 1'b0, code[2:0], bs[11:0]}, 4'hF);
    wr(2, {16'h1200, tm}, 4'hF);
    chk(cmd_start == 1'b1, {tag, " R5 cmd_start pulse"}, cmd_start, 1);
    while (!done && guard < 3000) begin
      guard++;
      req_ready = 1'($urandom_range(0, 1));
      #1;
      hs = req_valid && req_ready;
      if (req_valid) begin
        nchk++;
        if (req_addr !== a || req_len !== bs[11:0]) begin
          nfail++;
          $display("FAIL %s R12 request addr actual=0x%0h expected=0x%0h", tag, req_addr, a);
        end
      end
      @(negedge clk);
      if (hs) begin
        req_ready = 1'b0;
        lf = bleft(a, code);
        a = a + 32'(bs);
        if (!single) rem--;
        done = single || (rem == 0);
        chk(irq_done == done, {tag, " R9 irq_done"}, irq_done, done);
        chk(irq_bound == (!done && lf <= bs), {tag, " R10 irq_bound"}, irq_bound, (!done && lf <= bs));
        rd(1, d);
        chk(d[31:16] == (single ? cnt[15:0] : rem[15:0]), {tag, " R8/R9 count"}, d[31:16], single ? cnt : rem);
        if (done) begin
          chk(!busy && !req_valid, {tag, " R9 idle after done"}, busy, 0);
        end else if (lf <= bs) begin
          chk(busy && !req_valid, {tag, " R10 paused"}, {busy, req_valid}, 2);
          rd(0, d);
          chk(d == a, {tag, " R10 address at pause"}, d, a);
          repeat (2) @(negedge clk);
          chk(!req_valid, {tag, " R10 stays paused"}, req_valid, 0);
          wr(0, a, 4'hF);
          chk(req_valid == 1'b1, {tag, " R11 resume"}, req_valid, 1);
        end
      end
    end
    chk(done, {tag, " completion"}, done, 1);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 3; w++) begin
      rd(w[1:0], d);
      chk(d == 0, "R1 reset register", d, 0);
    end
    chk(!req_valid && !busy && !cmd_start && !irq_done && !irq_bound, "R1 reset outputs",
        {req_valid, busy, cmd_start, irq_done, irq_bound}, 0);

    wr(2, 32'hFFFF_FFFF, 4'b0011);
    chk(cmd_start == 1'b0, "R5 no pulse without upper byte", cmd_start, 0);
    rd(2, d);
    chk(d[15:0] == 16'h0037, "R2 mode mask", d[15:0], 16'h0037);
    cap_dma = 1'b0;
    wr(2, 32'h0000_FFFF, 4'b0011);
    rd(2, d);
    chk(d[15:0] == 16'h0036, "R3 DMA bit forced low", d[15:0], 16'h0036);
    cap_dma = 1'b1;

    wr(0, 32'h1122_3344, 4'hF);
    wr(0, 32'hAABB_CCDD, 4'b0101);
    rd(0, d);
    chk(d == 32'h11BB_33DD, "R4 partial write", d, 32'h11BB_33DD);
    wr(1, 32'hFFFF_FFFF, 4'b0011);
    rd(1, d);
    chk(d == 32'h0000_7FFF, "R4 block word bit 15", d, 32'h0000_7FFF);

    no_start("R7 multi without count enable", 16'h0021, 16'd4);
    no_start("R7 multi with zero count", 16'h0023, 16'd0);
    dma_sel = 2'd1;
    no_start("R6 other DMA type", 16'h0001, 16'd1);
    dma_sel = 2'd0;
    no_start("R6 DMA bit clear", 16'h0000, 16'd1);

    run_xfer("R8 single multi-clear", 32'h0000_4000, 512, 0, 5, 16'h0001);
    run_xfer("R8 single count one", 32'h0000_8000, 512, 0, 1, 16'h0033);
    chk(req_rd == 1'b1, "R2 direction bit", req_rd, 1);
    run_xfer("R9 multi no boundary", 32'h0000_0000, 512, 0, 4, 16'h0023);
    run_xfer("R10 early boundary", 32'h0000_0F00, 512, 0, 3, 16'h0023);
    run_xfer("R10 aligned boundary", 32'h0000_1C00, 1024, 0, 3, 16'h0023);

    void'($urandom(32'd20240611));
    for (int it = 0; it < 16; it++) begin
      int bs = $urandom_range(1, 2048);
      int code = (it < 8) ? 0 : $urandom_range(0, 2);
      int cnt = $urandom_range(2, 7);
      logic [31:0] a = $urandom() & 32'h0FFF_FFFF;
      run_xfer("R10 random", a, bs, code, cnt, 16'h0023);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule